// File: doc/BRIEF.md
# Dual-Channel Maskable Beam Permit Matrix

This block turns fourteen hardware permit lines and one software permit into a beam permit. It does so twice: channel A and channel B each have their own fourteen lines and their own fault lines. Each channel computes its own permit from its own lines only. A per-line fault input stands for a current loop that has dropped below its threshold. An asserted fault forces that line false, whatever level the line itself shows.

An operator register holds overrides for the lower seven lines. These are the overridable half. The upper seven lines are critical and can never be overridden. Overrides take effect only while the safe-beam flag is high. When the flag is low, every line counts as it stands.

In slave mode the channel permit is the AND of all fourteen lines and the software permit. In master mode each line carries a two-bit group number. The permit is then the AND across all used groups of the OR within each group, still ANDed with the software permit. Each permit passes through one register stage. A status output flags any disagreement between the two channels.

Top module: `redundant_permit_matrix`

## Requirements
- R1: In slave mode (masterMode=0) a channel permit is 1 only if swPermit is 1 and all 14 of its lines count as true. It appears at the first rising clock edge after the inputs are applied.
- R2: Lines 7 to 13 are critical. A low or faulted critical line drops the slave-mode permit, whatever the override register holds.
- R3: Lines 0 to 6 are overridable. While safeBeam is 1, a line whose override bit is set counts as true even when it is low or faulted.
- R4: While safeBeam is 0, all override bits are ignored and every line counts as it stands.
- R5: A fault bit set for a line forces that line false in its own channel.
- R6: Channel A uses only permitLinesA and faultA, and channel B uses only permitLinesB and faultB. The one swPermit line feeds both channels.
- R7: A write (maskWrEn=1) loads maskWrData bits 0 to 6 into the override register at the clock edge and drops bits 7 to 13. From that edge on, maskRdData shows the stored bits in positions 0 to 6 and zero in positions 7 to 13. An override change reaches the permit at the following edge.
- R8: While rstN is low, permitA, permitB and permitMismatch are 0 and the override register is cleared.
- R9: In master mode (masterMode=1), line i belongs to the group given by groupCfg bits [2i+1:2i]. The permit is 1 only if swPermit is 1 and every group that has at least one member has at least one true member. Groups with no members are ignored.
- R10: permitMismatch is 1 exactly when permitA and permitB differ, in the same cycle as those outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| permitLinesA | input | 14 | Channel A permit lines, 1 = permit |
| permitLinesB | input | 14 | Channel B permit lines, 1 = permit |
| faultA | input | 14 | Channel A per-line fault, 1 forces the line false |
| faultB | input | 14 | Channel B per-line fault, 1 forces the line false |
| swPermit | input | 1 | Software permit shared by both channels |
| safeBeam | input | 1 | 1 lets override bits take effect |
| masterMode | input | 1 | 0 = slave AND, 1 = master grouped AND of OR |
| groupCfg | input | 28 | Two-bit group number per line, line i at bits [2i+1:2i] |
| maskWrEn | input | 1 | Override register write strobe |
| maskWrData | input | 14 | Override write data, bits 7 to 13 dropped |
| maskRdData | output | 14 | Override register readback, upper seven bits always 0 |
| permitA | output | 1 | Registered channel A permit |
| permitB | output | 1 | Registered channel B permit |
| permitMismatch | output | 1 | 1 when permitA and permitB differ |

## Verification
The permits are due one edge after their inputs settle. An override write shows on maskRdData right after its edge, but reaches the permits one edge later. permitMismatch follows the permits with no extra delay. The bench model updates on each rising edge: it first evaluates the permits with the override value held before that edge, and only then applies any write. All four outputs are compared at the falling edge, half a cycle after every register has settled. Each check carries the tag of the requirement that the current stimulus phase targets.

// File: rtl/pim_pkg.sv
package pim_pkg;
  // strobes from control to the datapath
  typedef struct packed {
    logic maskGate;  // override bits may take effect
    logic orMode;    // grouped AND-of-OR evaluation
  } ctrlStrobe_t;
endpackage

// File: rtl/pim_control.sv
module pim_control
  import pim_pkg::*;
#(
  parameter int NUM_HW       = 14,
  parameter int NUM_MASKABLE = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              maskWrEn,
  input  logic [NUM_HW-1:0] maskWrData,
  input  logic              safeBeam,
  input  logic              masterMode,
  output ctrlStrobe_t       strobe,
  output logic [NUM_HW-1:0] maskVec
);
  localparam int NUM_CRIT = NUM_HW - NUM_MASKABLE;

  logic [NUM_MASKABLE-1:0] maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         maskQ <= '0;
    else if (maskWrEn) maskQ <= maskWrData[NUM_MASKABLE-1:0];
  end

  // critical positions hold no storage and read as zero
  assign maskVec = {{NUM_CRIT{1'b0}}, maskQ};

  always_comb begin
    strobe.maskGate = safeBeam;
    strobe.orMode   = masterMode;
  end
endmodule

// File: rtl/pim_channel.sv
module pim_channel
  import pim_pkg::*;
#(
  parameter int NUM_HW     = 14,
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_HW-1:0]         lines,
  input  logic [NUM_HW-1:0]         faults,
  input  logic [NUM_HW-1:0]         maskVec,
  input  ctrlStrobe_t               strobe,
  input  logic [NUM_HW*GROUP_W-1:0] groupCfg,
  input  logic                      swPermit,
  output logic                      permitQ
);
  logic [NUM_HW-1:0]     effective;
  logic [NUM_GROUPS-1:0] groupUsed;
  logic [NUM_GROUPS-1:0] groupHit;
  logic                  andAll;
  logic                  orTree;
  logic                  permitNext;

  assign effective = (lines & ~faults) | (maskVec & {NUM_HW{strobe.maskGate}});

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    always_comb begin
      groupUsed[g] = 1'b0;
      groupHit[g]  = 1'b0;
      for (int i = 0; i < NUM_HW; i++) begin
        if (groupCfg[i*GROUP_W +: GROUP_W] == GROUP_W'(g)) begin
          groupUsed[g] = 1'b1;
          groupHit[g]  = groupHit[g] | effective[i];
        end
      end
    end
  end

  assign andAll     = &effective;
  assign orTree     = &(groupHit | ~groupUsed);
  assign permitNext = swPermit & (strobe.orMode ? orTree : andAll);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) permitQ <= 1'b0;
    else       permitQ <= permitNext;
  end
endmodule

// File: rtl/pim_datapath.sv
module pim_datapath
  import pim_pkg::*;
#(
  parameter int NUM_HW     = 14,
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 2,
  parameter int NUM_CHAN   = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CHAN-1:0][NUM_HW-1:0] chLines,
  input  logic [NUM_CHAN-1:0][NUM_HW-1:0] chFaults,
  input  logic [NUM_HW-1:0]               maskVec,
  input  ctrlStrobe_t                     strobe,
  input  logic [NUM_HW*GROUP_W-1:0]       groupCfg,
  input  logic                            swPermit,
  output logic [NUM_CHAN-1:0]             chPermit
);
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    pim_channel #(
      .NUM_HW    (NUM_HW),
      .NUM_GROUPS(NUM_GROUPS),
      .GROUP_W   (GROUP_W)
    ) u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .lines   (chLines[c]),
      .faults  (chFaults[c]),
      .maskVec (maskVec),
      .strobe  (strobe),
      .groupCfg(groupCfg),
      .swPermit(swPermit),
      .permitQ (chPermit[c])
    );
  end
endmodule

// File: rtl/redundant_permit_matrix.sv
module redundant_permit_matrix
  import pim_pkg::*;
#(
  parameter int NUM_HW       = 14,
  parameter int NUM_MASKABLE = 7,
  parameter int NUM_GROUPS   = 4,
  parameter int GROUP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_HW-1:0]         permitLinesA,
  input  logic [NUM_HW-1:0]         permitLinesB,
  input  logic [NUM_HW-1:0]         faultA,
  input  logic [NUM_HW-1:0]         faultB,
  input  logic                      swPermit,
  input  logic                      safeBeam,
  input  logic                      masterMode,
  input  logic [NUM_HW*GROUP_W-1:0] groupCfg,
  input  logic                      maskWrEn,
  input  logic [NUM_HW-1:0]         maskWrData,
  output logic [NUM_HW-1:0]         maskRdData,
  output logic                      permitA,
  output logic                      permitB,
  output logic                      permitMismatch
);
  localparam int NUM_CHAN = 2;

  ctrlStrobe_t                     strobe;
  logic [NUM_HW-1:0]               maskVec;
  logic [NUM_CHAN-1:0]             chPermit;
  logic [NUM_CHAN-1:0][NUM_HW-1:0] chLines;
  logic [NUM_CHAN-1:0][NUM_HW-1:0] chFaults;

  assign chLines  = {permitLinesB, permitLinesA};
  assign chFaults = {faultB, faultA};

  pim_control #(
    .NUM_HW      (NUM_HW),
    .NUM_MASKABLE(NUM_MASKABLE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .maskWrEn  (maskWrEn),
    .maskWrData(maskWrData),
    .safeBeam  (safeBeam),
    .masterMode(masterMode),
    .strobe    (strobe),
    .maskVec   (maskVec)
  );

  pim_datapath #(
    .NUM_HW    (NUM_HW),
    .NUM_GROUPS(NUM_GROUPS),
    .GROUP_W   (GROUP_W),
    .NUM_CHAN  (NUM_CHAN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chLines (chLines),
    .chFaults(chFaults),
    .maskVec (maskVec),
    .strobe  (strobe),
    .groupCfg(groupCfg),
    .swPermit(swPermit),
    .chPermit(chPermit)
  );

  assign maskRdData     = maskVec;
  assign permitA        = chPermit[0];
  assign permitB        = chPermit[1];
  assign permitMismatch = chPermit[0] ^ chPermit[1];
endmodule

// File: rtl/redundant_permit_matrix_chk.sv
module redundant_permit_matrix_chk #(
  parameter int NUM_HW       = 14,
  parameter int NUM_MASKABLE = 7,
  parameter int GROUP_W      = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_HW-1:0]         permitLinesA,
  input logic [NUM_HW-1:0]         permitLinesB,
  input logic [NUM_HW-1:0]         faultA,
  input logic [NUM_HW-1:0]         faultB,
  input logic                      swPermit,
  input logic                      safeBeam,
  input logic                      masterMode,
  input logic [NUM_HW-1:0]         maskRdData,
  input logic                      permitA,
  input logic                      permitB,
  input logic                      permitMismatch
);
  // R2 / R5: a dropped or faulted critical line blocks the slave permit
  a_r2_critical_a: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !(&(permitLinesA[NUM_HW-1:NUM_MASKABLE] & ~faultA[NUM_HW-1:NUM_MASKABLE])))
    |=> !permitA);
  a_r5_critical_b: assert property (@(posedge clk) disable iff (!rstN)
    (!masterMode && !(&(permitLinesB[NUM_HW-1:NUM_MASKABLE] & ~faultB[NUM_HW-1:NUM_MASKABLE])))
    |=> !permitB);
  // R4: without the safe-beam flag any bad line blocks the slave permit
  a_r4_unsafe_a: assert property (@(posedge clk) disable iff (!rstN)
    (!safeBeam && !masterMode && !(&(permitLinesA & ~faultA))) |=> !permitA);
  // R1: software permit low blocks both channels
  a_r1_sw_block: assert property (@(posedge clk) disable iff (!rstN)
    !swPermit |=> (!permitA && !permitB));
  // R10: identical channel stimulus never yields a mismatch
  a_r10_no_split: assert property (@(posedge clk) disable iff (!rstN)
    (permitLinesA == permitLinesB && faultA == faultB) |=> !permitMismatch);
  // R7: critical positions of the readback stay zero
  a_r7_crit_readback: assert property (@(posedge clk) disable iff (!rstN)
    maskRdData[NUM_HW-1:NUM_MASKABLE] == '0);
  // R8: outputs are low at the first edge after reset release
  a_r8_reset_low: assert property (@(posedge clk)
    $rose(rstN) |-> (!permitA && !permitB && !permitMismatch && maskRdData == '0));
endmodule

bind redundant_permit_matrix redundant_permit_matrix_chk #(
  .NUM_HW      (NUM_HW),
  .NUM_MASKABLE(NUM_MASKABLE),
  .GROUP_W     (GROUP_W)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .permitLinesA  (permitLinesA),
  .permitLinesB  (permitLinesB),
  .faultA        (faultA),
  .faultB        (faultB),
  .swPermit      (swPermit),
  .safeBeam      (safeBeam),
  .masterMode    (masterMode),
  .maskRdData    (maskRdData),
  .permitA       (permitA),
  .permitB       (permitB),
  .permitMismatch(permitMismatch)
);

// File: tb/redundant_permit_matrix_test.sv
module redundant_permit_matrix_test;
  localparam int CLK_PERIOD = 10;
  localparam int NHW = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NHW-1:0] linesA = '1, linesB = '1, fltA = '0, fltB = '0;
  logic swPermit = 1'b1, safeBeam = 1'b0, masterMode = 1'b0;
  logic [2*NHW-1:0] groupCfg = '0;
  logic maskWrEn = 1'b0;
  logic [NHW-1:0] maskWrData = '0;
  logic [NHW-1:0] maskRdData;
  logic permitA, permitB, permitMismatch;

  int tests = 0, fails = 0;
  bit cmpOn = 0, done = 0;
  string tag = "R8";

  bit expA = 0, expB = 0;
  bit [6:0] modelMask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  redundant_permit_matrix uut (
    .clk(clk), .rstN(rstN), .permitLinesA(linesA), .permitLinesB(linesB),
    .faultA(fltA), .faultB(fltB), .swPermit(swPermit), .safeBeam(safeBeam),
    .masterMode(masterMode), .groupCfg(groupCfg), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .maskRdData(maskRdData), .permitA(permitA),
    .permitB(permitB), .permitMismatch(permitMismatch));

  function automatic bit refPermit(bit [13:0] ln, bit [13:0] fl, bit [6:0] mk,
                                   bit sb, bit sw, bit ms, bit [27:0] gc);
    bit [13:0] ok;
    for (int i = 0; i < 14; i++)
      ok[i] = (ln[i] && !fl[i]) || (i < 7 && sb && mk[i]);
    if (!sw) return 0;
    if (!ms) begin
      for (int i = 0; i < 14; i++) if (!ok[i]) return 0;
      return 1;
    end
    for (int g = 0; g < 4; g++) begin
      int members = 0, good = 0;
      for (int i = 0; i < 14; i++)
        if (int'(gc[2*i +: 2]) == g) begin
          members++;
          if (ok[i]) good++;
        end
      if (members > 0 && good == 0) return 0;
    end
    return 1;
  endfunction

  // reference model: evaluate with the old override value, then apply writes
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expA = 0; expB = 0; modelMask = '0;
    end else begin
      expA = refPermit(linesA, fltA, modelMask, safeBeam, swPermit, masterMode, groupCfg);
      expB = refPermit(linesB, fltB, modelMask, safeBeam, swPermit, masterMode, groupCfg);
      if (maskWrEn) modelMask = maskWrData[6:0];
    end
  end

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check(tag, "permitA", 16'(permitA), 16'(expA));
      check(tag, "permitB", 16'(permitB), 16'(expB));
      check("R10", "permitMismatch", 16'(permitMismatch), 16'(expA != expB));
      check("R7", "maskRdData", 16'(maskRdData), {9'd0, modelMask});
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R8: outputs low during reset, write under reset has no effect
    maskWrEn = 1'b1; maskWrData = '1;
    step(3);
    check("R8", "permitA in reset", 16'(permitA), 16'd0);
    check("R8", "permitB in reset", 16'(permitB), 16'd0);
    check("R8", "readback in reset", 16'(maskRdData), 16'd0);
    maskWrEn = 1'b0;
    rstN = 1'b1;
    cmpOn = 1;
    // R1: all good lines give a permit
    tag = "R1"; step(3);
    check("R1", "permitA all good", 16'(permitA), 16'd1);
    for (int i = 0; i < NHW; i++) begin
      linesA = '1; linesA[i] = 1'b0; step(2);
    end
    linesA = '1;
    swPermit = 1'b0; step(2);
    check("R1", "software permit low", 16'(permitA | permitB), 16'd0);
    swPermit = 1'b1; step(2);
    // R7: upper write bits dropped
    tag = "R7";
    maskWrEn = 1'b1; maskWrData = 14'h3FFF; step(1);
    maskWrEn = 1'b0;
    check("R7", "readback after full write", 16'(maskRdData), 16'h007F);
    step(1);
    // R3: overridden lower lines with safe beam
    tag = "R3"; safeBeam = 1'b1;
    linesA = 14'h3F80; linesB = 14'h3F80; step(3);
    check("R3", "lower lines overridden", 16'(permitA & permitB), 16'd1);
    fltA = 14'h0005; step(2);
    // R2: critical lines cannot be overridden
    tag = "R2"; fltA = '0; linesA = 14'h3B80; step(3);
    check("R2", "critical line 10 low", 16'(permitA), 16'd0);
    linesA = 14'h3F80; step(2);
    // R4: safe beam low ignores overrides
    tag = "R4"; safeBeam = 1'b0; step(3);
    check("R4", "overrides ignored", 16'(permitA | permitB), 16'd0);
    linesA = '1; linesB = '1; linesA[3] = 1'b0; step(2);
    linesA = '1;
    // R5: fault forces line false
    tag = "R5"; fltB[12] = 1'b1; step(3);
    check("R5", "fault line 12 on B", 16'(permitB), 16'd0);
    fltB = '0;
    // R7: partial rewrite, timing of readback vs permit
    tag = "R7"; safeBeam = 1'b1; linesA[4] = 1'b0; linesB[4] = 1'b0;
    maskWrEn = 1'b1; maskWrData = 14'h0001; step(1);
    maskWrEn = 1'b0; step(2);
    maskWrEn = 1'b1; maskWrData = 14'h0010; step(1);
    maskWrEn = 1'b0; step(2);
    check("R7", "line 4 overridden after write", 16'(permitA), 16'd1);
    linesA = '1; linesB = '1;
    // R6 / R10: channels independent
    tag = "R6"; linesB[5] = 1'b0; linesB[0] = 1'b1; fltB[8] = 1'b1; step(3);
    check("R6", "A unaffected by B lines", 16'(permitA), 16'd1);
    check("R10", "mismatch raised", 16'(permitMismatch), 16'd1);
    fltB = '0; linesB = '1; fltA[9] = 1'b1; step(3);
    fltA = '0; step(2);
    // R9: master grouping, line i in group i%4
    tag = "R9"; masterMode = 1'b1; safeBeam = 1'b0;
    for (int i = 0; i < NHW; i++) groupCfg[2*i +: 2] = 2'(i % 4);
    linesA = '1; linesA[1] = 0; linesA[5] = 0; linesA[9] = 0; step(3);
    check("R9", "partial group still ok", 16'(permitA), 16'd1);
    linesA[13] = 1'b0; step(3);
    check("R9", "group 1 all low", 16'(permitA), 16'd0);
    groupCfg = '0; linesA = 14'h0100; step(3);
    check("R9", "single group OR", 16'(permitA), 16'd1);
    linesA = '0; step(2);
    linesA = '1;
    // mixed random patterns in both modes
    for (int k = 0; k < 60; k++) begin
      linesA = NHW'(~($urandom & $urandom & $urandom));
      linesB = (k % 3 == 0) ? linesA : NHW'(~($urandom & $urandom));
      fltA = NHW'($urandom & $urandom & $urandom & $urandom);
      fltB = (k % 3 == 0) ? fltA : '0;
      safeBeam = 1'($urandom);
      masterMode = 1'($urandom);
      groupCfg = 28'($urandom);
      maskWrEn = (k % 7 == 0);
      maskWrData = NHW'($urandom);
      swPermit = ($urandom % 8) != 0;
      tag = masterMode ? "R9" : "R1";
      step(1);
    end
    maskWrEn = 1'b0;
    step(2);
    finishRun();
  end
endmodule